// File: doc/BRIEF.md
# Loop Stage Predicate Sequencer

This block steers a four-stage software-pipelined loop. The stages are A (load), B and C (logic), and D (store). Each stage has its own predicate bit. A shift register moves the predicates forward by one stage on every kernel step, so one kernel body covers filling, steady state and draining of the pipeline. No separate prologue or epilogue is needed. While the remaining trip count is above zero, a 1 is fed into stage A. Once the count is used up, 0s are fed in, and the already-started iterations flow out through D.

A start pulse loads the trip count and arms the first stage. The advance strobe marks each executed kernel step. A stage may commit its result only on a kernel step in which its predicate is set. When the count is used up and every predicate is clear, busy falls and a one-cycle done pulse is given.

The controller is a three-state machine with these states:
- IDLE waits for start.
- RUN steps the predicates.
- FINISH gives the done pulse.

It has these transitions:
- IDLE to RUN is taken on start with a nonzero count (launch).
- IDLE to FINISH is taken on start with a zero count (empty).
- RUN to FINISH is taken on the step that clears the last predicate (drained).
- FINISH to IDLE is taken unconditionally (retire).
- Every other case holds the current state.

Top module: `stage_gate_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all predicates and the remaining count. After that edge, busy and done are low and the state is IDLE.
- R2: commit_o[s] is high only when adv_i is high, busy is high, and pred_o[s] is set. Bit 0 is stage A, bit 1 is B, bit 2 is C and bit 3 is D.
- R3: After a start with count N>0, pred_o reads 4'b0001. Before kernel step k (counted from 1), stage s is predicated exactly when 1 <= k-s <= N.
- R4: While running, the predicates shift up by one stage only on a clock with adv_i high. On other clocks they hold their value.
- R5: The bit fed into stage A is 1 while the remaining count is above zero. Each 1 fed in lowers the count by one.
- R6: With count N>0, the loop takes exactly N+3 kernel steps, and each of the four stages commits exactly N times.
- R7: Done is high for exactly one clock, in the cycle after the step that clears the last predicate. busy is low from that cycle on, and all predicates are zero.
- R8: A start pulse is accepted only from IDLE. A start during RUN or during the done cycle changes neither the predicates, the count nor the state.
- R9: A count of zero gives done in the cycle after start, with no commits. An advance strobe while not running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, accepted in IDLE only |
| trip_i | input | CNT_W | Trip count sampled on an accepted start |
| adv_i | input | 1 | Kernel-step strobe |
| pred_o | output | NSTAGE | Stage predicates for the next kernel step, bit 0 = A |
| commit_o | output | NSTAGE | Per-stage commit enables for the current step |
| busy_o | output | 1 | High while in RUN |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The testbench sweeps every trip count from 0 to 9 under three advance patterns:
- A continuous strobe shows that the predicate sequence follows the kernel-step count and not raw clock cycles.
- An alternating strobe exposes any shift or commit on a non-step cycle.
- An irregular strobe separates hold behaviour from shift behaviour.

Counts 1 to 3 make the fill and drain phases overlap, and zero covers the empty loop. Start pulses injected during RUN and during the done cycle, an advance while idle, and a reset mid-loop tell correct ignoring and clearing apart from state corruption.

// File: rtl/stage_seq_pkg.sv
package stage_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/stage_pred_shift.sv
module stage_pred_shift #(
    parameter int NSTAGE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              load_bit_i,
    input  logic              step_i,
    input  logic              feed_i,
    output logic [NSTAGE-1:0] pred_o
);
    logic [NSTAGE-1:0] q;

    // Stage 0 takes the feed bit; every later stage takes its lower neighbour.
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        logic d;
        if (s == 0) begin : g_head
            always_comb begin
                if (load_i)      d = load_bit_i;
                else if (step_i) d = feed_i;
                else             d = q[0];
            end
        end else begin : g_tail
            always_comb begin
                if (load_i)      d = 1'b0;
                else if (step_i) d = q[s-1];
                else             d = q[s];
            end
        end
        always_ff @(posedge clk) begin
            if (rst) q[s] <= 1'b0;
            else     q[s] <= d;
        end
    end

    assign pred_o = q;
endmodule

// File: rtl/trip_counter.sv
module trip_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] trip_i,
    input  logic             step_i,
    output logic             feed_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;
    logic             trip_nz;

    assign trip_nz = |trip_i;
    assign feed_o  = |remain_q;

    // On load, the first entry into stage A is already accounted for.
    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= trip_nz ? trip_i - ONE : '0;
        end else if (step_i && feed_o) begin
            remain_q <= remain_q - ONE;
        end
    end
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import stage_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic trip_zero_i,
    input  logic adv_i,
    input  logic drain_end_i,
    output logic load_o,
    output logic run_o,
    output logic done_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = trip_zero_i ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (adv_i && drain_end_i) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        run_o  = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = start_i;
            ST_RUN:    run_o  = 1'b1;
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/stage_gate_seq.sv
module stage_gate_seq #(
    parameter int NSTAGE = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  trip_i,
    input  logic              adv_i,
    output logic [NSTAGE-1:0] pred_o,
    output logic [NSTAGE-1:0] commit_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int LOW_W = NSTAGE - 1;

    logic load, run, step, feed, drain_end, trip_zero;
    logic [NSTAGE-1:0] pred;

    assign trip_zero = ~(|trip_i);
    assign step      = adv_i & run;
    // The step that shifts out the top predicate, with nothing left to feed.
    assign drain_end = ~feed & ~(|pred[LOW_W-1:0]);

    seq_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .trip_zero_i (trip_zero),
        .adv_i       (adv_i),
        .drain_end_i (drain_end),
        .load_o      (load),
        .run_o       (run),
        .done_o      (done_o)
    );

    trip_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .trip_i (trip_i),
        .step_i (step),
        .feed_o (feed)
    );

    stage_pred_shift #(.NSTAGE(NSTAGE)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_bit_i (~trip_zero),
        .step_i     (step),
        .feed_i     (feed),
        .pred_o     (pred)
    );

    for (genvar s = 0; s < NSTAGE; s++) begin : g_commit
        assign commit_o[s] = pred[s] & step;
    end

    assign pred_o = pred;
    assign busy_o = run;
endmodule

// File: rtl/stage_gate_seq_chk.sv
module stage_gate_seq_chk #(
    parameter int NSTAGE = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              adv_i,
    input logic [NSTAGE-1:0] pred_o,
    input logic [NSTAGE-1:0] commit_o,
    input logic              busy_o,
    input logic              done_o
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pred_o == '0) && !busy_o && !done_o);

    // R2
    a_r2_commit_gated: assert property (@(posedge clk) disable iff (rst)
        (commit_o & ~pred_o) == '0);
    a_r2_commit_needs_step: assert property (@(posedge clk) disable iff (rst)
        !(adv_i && busy_o) |-> commit_o == '0);

    // R4
    a_r4_shift_on_step: assert property (@(posedge clk) disable iff (rst)
        busy_o && adv_i |=> pred_o[NSTAGE-1:1] == $past(pred_o[NSTAGE-2:0]));
    a_r4_hold_no_step: assert property (@(posedge clk) disable iff (rst)
        busy_o && !adv_i |=> $stable(pred_o) && busy_o);

    // R7
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && pred_o == '0);

    // R8
    a_r8_start_in_run: assert property (@(posedge clk) disable iff (rst)
        busy_o && start_i && !adv_i |=> busy_o && $stable(pred_o));
    a_r8_start_in_done: assert property (@(posedge clk) disable iff (rst)
        done_o && start_i |=> !busy_o && !done_o);
endmodule

bind stage_gate_seq stage_gate_seq_chk #(.NSTAGE(NSTAGE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .adv_i    (adv_i),
    .pred_o   (pred_o),
    .commit_o (commit_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/stage_gate_seq_tb_top.sv
`timescale 1ns/1ps
module stage_gate_seq_tb_top;
    localparam int NS = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [CW-1:0] trip_i = '0;
    logic          adv_i = 1'b0;
    logic [NS-1:0] pred_o, commit_o;
    logic          busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stage_gate_seq #(.NSTAGE(NS), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .trip_i(trip_i),
        .adv_i(adv_i), .pred_o(pred_o), .commit_o(commit_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Predicates expected before kernel step k for trip count n.
    function automatic logic [NS-1:0] exp_pred(input int k, input int n);
        logic [NS-1:0] p = '0;
        for (int s = 0; s < NS; s++)
            if (k - s >= 1 && k - s <= n) p[s] = 1'b1;
        return p;
    endfunction

    function automatic bit adv_pat(input int mode, input int cyc, input int n);
        case (mode)
            0: return 1'b1;
            1: return cyc[0];
            default: return ((cyc * 7 + n) % 3) != 0;
        endcase
    endfunction

    task automatic run_loop(input int n, input int mode);
        int steps = 0;
        int cyc = 0;
        int cnt [NS];
        for (int s = 0; s < NS; s++) cnt[s] = 0;
        @(negedge clk);
        start_i = 1'b1; trip_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0; trip_i = '0;
        if (n == 0) begin
            chk(done_o === 1'b1 && busy_o === 1'b0, "R9 zero trip done", int'(done_o), 1);
            chk(commit_o === '0, "R9 zero trip commit", int'(commit_o), 0);
        end else begin
            chk(pred_o === 4'b0001, "R3 armed after start", int'(pred_o), 1);
            while (busy_o === 1'b1 && cyc < 200) begin
                adv_i = adv_pat(mode, cyc, n);
                // R8: start with another count injected mid-run
                if (mode == 1 && cyc == 1) begin start_i = 1'b1; trip_i = CW'(n + 5); end
                else begin start_i = 1'b0; trip_i = '0; end
                #1;
                chk(pred_o === exp_pred(steps + 1, n), "R3 R4 R5 predicates", int'(pred_o),
                    int'(exp_pred(steps + 1, n)));
                chk(commit_o === (adv_i ? exp_pred(steps + 1, n) : '0), "R2 commit",
                    int'(commit_o), int'(adv_i ? exp_pred(steps + 1, n) : '0));
                for (int s = 0; s < NS; s++) cnt[s] += int'(commit_o[s]);
                if (adv_i) steps++;
                cyc++;
                @(negedge clk);
            end
            adv_i = 1'b0; start_i = 1'b0;
            chk(steps == n + 3, "R6 step count", steps, n + 3);
            for (int s = 0; s < NS; s++)
                chk(cnt[s] == n, "R6 R8 commits per stage", cnt[s], n);
            chk(done_o === 1'b1 && pred_o === '0, "R7 done after drain", int'(done_o), 1);
        end
        // R8: start during the done cycle must be ignored
        if (mode == 2) begin start_i = 1'b1; trip_i = 8'd3; end
        @(negedge clk);
        start_i = 1'b0; trip_i = '0;
        chk(done_o === 1'b0 && busy_o === 1'b0, "R7 R8 done single, stays idle",
            int'({busy_o, done_o}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pred_o === '0 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset state",
            int'(pred_o), 0);
        rst = 1'b0;
        // R9: advance while idle
        adv_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(pred_o === '0 && commit_o === '0 && busy_o === 1'b0, "R9 idle advance",
                int'(commit_o), 0);
        end
        adv_i = 1'b0;
        for (int mode = 0; mode < 3; mode++)
            for (int n = 0; n < 10; n++)
                run_loop(n, mode);
        // R1: reset mid-loop
        @(negedge clk);
        start_i = 1'b1; trip_i = 8'd6;
        @(negedge clk);
        start_i = 1'b0; adv_i = 1'b1;
        repeat (3) @(negedge clk);
        adv_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(pred_o === '0 && busy_o === 1'b0 && done_o === 1'b0, "R1 mid-loop reset",
            int'(pred_o), 0);
        rst = 1'b0;
        run_loop(2, 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule